// File: doc/BRIEF.md
# Backup Power Domain Switch Sequencer

This block runs on the always-on slow clock. It drives the power switches and active-low resets of three sub-domains that stay alive in backup: a real-time clock domain, a retention SRAM, and the supply-source selection of an LCD regulator. Software uses a single-cycle write strobe to load three fields: the clock-domain power enable, the SRAM keep-alive bit and a two-bit LCD source mode. A supervisory supply controller signals entry into and exit from backup mode.

Switching the clock domain waits a fixed resynchronisation delay after the write. On power-up the switch closes, and the domain reset is released one cycle later. On power-down the reset is asserted first, and the switch opens one cycle later. A status flag reports when each sequence has finished, and software polls it before the next enable write. A write that arrives while a sequence is still running is dropped and raises a sticky error flag. The SRAM keep-alive bit acts only when backup mode is entered. The LCD reset is released one cycle after a supply source is selected.

Top module: `bkp_domain_seq`

## Requirements
- R1: A write that changes the clock-domain enable from 0 to 1, sampled at edge k, sets `rtc_sw_on` at edge k+SYNC_CYC (default 2) and releases `rtc_dom_rst_n` at edge k+SYNC_CYC+1. `rtc_dom_rst_n` is never high while `rtc_sw_on` is low.
- R2: A write that changes the enable from 1 to 0, sampled at edge k, drives `rtc_dom_rst_n` low at edge k+SYNC_CYC and `rtc_sw_on` low at edge k+SYNC_CYC+1.
- R3: When no sequence is running, a write whose `wr_rtc_on` equals the current enable changes no output.
- R4: `rtc_sts` rises in the same edge that completes a power-up (reset released). It falls in the same edge that completes a power-down (switch opened).
- R5: A write strobe sampled from edge k+1 through edge k+SYNC_CYC+1 of a running sequence leaves the clock domain untouched and sets `seq_err` at that edge. `seq_err` then holds until a sampled `err_clr`. When a set and a clear fall in the same cycle, the set wins. A write at edge k+SYNC_CYC+2 is accepted.
- R6: While `rst_n` is low: `rtc_sw_on`=0, `rtc_dom_rst_n`=0, `rtc_sts`=0, `seq_err`=0, `sram_sw_on`=1, both LCD selects 0, `lcd_dom_rst_n`=0. The enable, keep-alive and mode fields reset to 0.
- R7: Writing `wr_sram_keep` does not change `sram_sw_on`. A sampled `bkp_enter` loads `sram_sw_on` with the keep-alive bit held before that edge, in the same edge.
- R8: A sampled `bkp_exit` sets `sram_sw_on` to 1 at that edge, whatever the keep-alive bit holds. It overrides a simultaneous `bkp_enter`.
- R9: Mode 1 selects the external supply (`lcd_sel_ext`) and mode 2 selects the charge pump (`lcd_sel_pump`). Modes 0 and 3 select neither. The selects follow the stored mode one edge after the write edge, and at most one is high.
- R10: `lcd_dom_rst_n` is low while no source is selected and in the edge where the selection changes. It goes high one edge after a nonzero selection has taken effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow clock |
| rst_n | input | 1 | Asynchronous active-low backup reset |
| wr_en | input | 1 | Single-cycle write strobe for all three fields |
| wr_rtc_on | input | 1 | Requested clock-domain power enable |
| wr_sram_keep | input | 1 | SRAM keep-alive bit for the next backup entry |
| wr_lcd_mode | input | 2 | LCD supply mode: 0 none, 1 external, 2 pump, 3 none |
| err_clr | input | 1 | Clears the sticky sequence error flag |
| bkp_enter | input | 1 | Backup-mode entry pulse |
| bkp_exit | input | 1 | Backup-mode exit pulse |
| rtc_sw_on | output | 1 | Clock-domain power switch enable |
| rtc_dom_rst_n | output | 1 | Clock-domain active-low reset |
| rtc_sts | output | 1 | Clock domain powered and out of reset |
| seq_err | output | 1 | Sticky flag: enable write hit a running sequence |
| sram_sw_on | output | 1 | Retention SRAM power switch enable |
| lcd_sel_ext | output | 1 | LCD regulator fed from external supply |
| lcd_sel_pump | output | 1 | LCD regulator fed from charge pump |
| lcd_dom_rst_n | output | 1 | LCD controller active-low reset |

## Verification
The clock-domain switch and reset are due SYNC_CYC and SYNC_CYC+1 edges after the write edge. The error flag, the SRAM switch and the LCD mode register settle in the strobe's own edge. The LCD selects follow one edge later and the LCD reset one edge after that. The bench's reference model tracks the edge at which each write was accepted and schedules these events by edge count. Every output is compared with the model at each falling edge, so an effect that comes one cycle early or late is caught. Directed checks add the boundary writes: the last busy edge, the first free edge, and a set-and-clear collision.

// File: rtl/bkp_seq_pkg.sv
package bkp_seq_pkg;

   typedef enum logic [1:0] {
      RTC_IDLE = 2'd0,
      RTC_SYNC = 2'd1,
      RTC_STEP = 2'd2
   } rtc_state_t;

   localparam int LCD_MODE_W = 2;
   localparam int LCD_NSRC   = 2;

endpackage

// File: rtl/bkp_rtc_seq.sv
module bkp_rtc_seq
   import bkp_seq_pkg::*;
#(
   parameter int SYNC_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_on,
   input  logic err_clr,
   output logic sw_on,
   output logic dom_rst_n,
   output logic sts,
   output logic err
);
   localparam int CW = $clog2(SYNC_CYC + 1);

   generate
      if (SYNC_CYC < 1) begin : g_bad_sync
         $error("SYNC_CYC must be at least 1");
      end
   endgenerate

   rtc_state_t      st_q;
   logic [CW-1:0]   cnt_q;
   logic            en_q;
   logic            busy;

   assign busy = (st_q != RTC_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= RTC_IDLE;
         cnt_q     <= '0;
         en_q      <= 1'b0;
         sw_on     <= 1'b0;
         dom_rst_n <= 1'b0;
         sts       <= 1'b0;
         err       <= 1'b0;
      end else begin
         if (err_clr) begin
            err <= 1'b0;
         end
         if (wr_en && busy) begin
            err <= 1'b1;
         end
         case (st_q)
            RTC_IDLE: begin
               if (wr_en && (wr_on != en_q)) begin
                  en_q  <= wr_on;
                  cnt_q <= CW'(SYNC_CYC - 1);
                  st_q  <= RTC_SYNC;
               end
            end
            RTC_SYNC: begin
               if (cnt_q == '0) begin
                  if (en_q) begin
                     sw_on <= 1'b1;
                  end else begin
                     dom_rst_n <= 1'b0;
                  end
                  st_q <= RTC_STEP;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            RTC_STEP: begin
               if (en_q) begin
                  dom_rst_n <= 1'b1;
                  sts       <= 1'b1;
               end else begin
                  sw_on <= 1'b0;
                  sts   <= 1'b0;
               end
               st_q <= RTC_IDLE;
            end
            default: st_q <= RTC_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/bkp_sram_sw.sv
module bkp_sram_sw (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_keep,
   input  logic bkp_enter,
   input  logic bkp_exit,
   output logic sw_on
);
   logic keep_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         keep_q <= 1'b0;
         sw_on  <= 1'b1;
      end else begin
         if (wr_en) begin
            keep_q <= wr_keep;
         end
         if (bkp_exit) begin
            sw_on <= 1'b1;
         end else if (bkp_enter) begin
            sw_on <= keep_q;
         end
      end
   end

endmodule

// File: rtl/bkp_lcd_sel.sv
module bkp_lcd_sel #(
   parameter int MODE_W = 2,
   parameter int NSRC   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [MODE_W-1:0] wr_mode,
   output logic [NSRC-1:0]   sel,
   output logic              dom_rst_n
);
   generate
      if (NSRC < 1 || NSRC >= (1 << MODE_W)) begin : g_bad_nsrc
         $error("NSRC must fit in the nonzero mode codes");
      end
   endgenerate

   logic [MODE_W-1:0] mode_q;
   logic [NSRC-1:0]   sel_d;

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_src
         assign sel_d[i] = (mode_q == MODE_W'(i + 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= '0;
         sel       <= '0;
         dom_rst_n <= 1'b0;
      end else begin
         if (wr_en) begin
            mode_q <= wr_mode;
         end
         sel       <= sel_d;
         dom_rst_n <= (|sel) && (sel == sel_d);
      end
   end

endmodule

// File: rtl/bkp_domain_seq.sv
module bkp_domain_seq
   import bkp_seq_pkg::*;
#(
   parameter int SYNC_CYC = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic                  wr_rtc_on,
   input  logic                  wr_sram_keep,
   input  logic [LCD_MODE_W-1:0] wr_lcd_mode,
   input  logic                  err_clr,
   input  logic                  bkp_enter,
   input  logic                  bkp_exit,
   output logic                  rtc_sw_on,
   output logic                  rtc_dom_rst_n,
   output logic                  rtc_sts,
   output logic                  seq_err,
   output logic                  sram_sw_on,
   output logic                  lcd_sel_ext,
   output logic                  lcd_sel_pump,
   output logic                  lcd_dom_rst_n
);
   logic [LCD_NSRC-1:0] lcd_sel;

   bkp_rtc_seq #(.SYNC_CYC(SYNC_CYC)) i_rtc (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_on     (wr_rtc_on),
      .err_clr   (err_clr),
      .sw_on     (rtc_sw_on),
      .dom_rst_n (rtc_dom_rst_n),
      .sts       (rtc_sts),
      .err       (seq_err)
   );

   bkp_sram_sw i_sram (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_keep   (wr_sram_keep),
      .bkp_enter (bkp_enter),
      .bkp_exit  (bkp_exit),
      .sw_on     (sram_sw_on)
   );

   bkp_lcd_sel #(.MODE_W(LCD_MODE_W), .NSRC(LCD_NSRC)) i_lcd (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_mode   (wr_lcd_mode),
      .sel       (lcd_sel),
      .dom_rst_n (lcd_dom_rst_n)
   );

   assign lcd_sel_ext  = lcd_sel[0];
   assign lcd_sel_pump = lcd_sel[1];

endmodule

// File: rtl/bkp_domain_seq_chk.sv
module bkp_domain_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic       wr_rtc_on,
   input logic       wr_sram_keep,
   input logic [1:0] wr_lcd_mode,
   input logic       err_clr,
   input logic       bkp_enter,
   input logic       bkp_exit,
   input logic       rtc_sw_on,
   input logic       rtc_dom_rst_n,
   input logic       rtc_sts,
   input logic       seq_err,
   input logic       sram_sw_on,
   input logic       lcd_sel_ext,
   input logic       lcd_sel_pump,
   input logic       lcd_dom_rst_n
);
   AST_RTC_RST_NEEDS_SW: assert property (@(posedge clk) disable iff (!rst_n)
      rtc_dom_rst_n |-> rtc_sw_on); // R1
   AST_RTC_UP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rtc_dom_rst_n) |-> $past(rtc_sw_on)); // R1
   AST_RTC_DOWN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rtc_sw_on) |-> $past(!rtc_dom_rst_n)); // R2
   AST_STS_RISE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rtc_sts) |-> rtc_dom_rst_n); // R4
   AST_STS_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rtc_sts) |-> !rtc_sw_on); // R4
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_err && !err_clr) |=> seq_err); // R5
   AST_SRAM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!bkp_enter && !bkp_exit) |=> $stable(sram_sw_on)); // R7
   AST_SRAM_EXIT_ON: assert property (@(posedge clk) disable iff (!rst_n)
      bkp_exit |=> sram_sw_on); // R8
   AST_LCD_ONE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({lcd_sel_ext, lcd_sel_pump})); // R9
   AST_LCD_REL_AFTER_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lcd_dom_rst_n) |-> ((lcd_sel_ext || lcd_sel_pump)
                                && $stable({lcd_sel_ext, lcd_sel_pump}))); // R10
endmodule

bind bkp_domain_seq bkp_domain_seq_chk i_chk (.*);

// File: tb/test_bkp_domain_seq.sv
module test_bkp_domain_seq;
   localparam int CLK_PERIOD = 10;
   localparam int SYNC       = 2;
   localparam int WD_LIMIT   = 5000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, wr_rtc_on = 1'b0, wr_sram_keep = 1'b0;
   logic [1:0] wr_lcd_mode = 2'd0;
   logic       err_clr = 1'b0, bkp_enter = 1'b0, bkp_exit = 1'b0;
   logic       rtc_sw_on, rtc_dom_rst_n, rtc_sts, seq_err, sram_sw_on;
   logic       lcd_sel_ext, lcd_sel_pump, lcd_dom_rst_n;

   bkp_domain_seq #(.SYNC_CYC(SYNC)) i_bkp_domain_seq (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0, n_fail = 0, cyc = 0, t0 = 0;
   bit done = 1'b0;

   // behavioural reference model
   bit m_en = 0, m_busy = 0, m_sw = 0, m_rst = 0, m_sts = 0, m_err = 0;
   bit m_keep = 0, m_sram = 1, m_lrst = 0, busy_old = 0;
   int m_mode = 0, m_sel = 0, sel_new = 0;

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_en = 0; m_busy = 0; m_sw = 0; m_rst = 0; m_sts = 0; m_err = 0;
         m_keep = 0; m_sram = 1; m_mode = 0; m_sel = 0; m_lrst = 0;
      end else begin
         busy_old = m_busy;
         if (err_clr) m_err = 0;
         if (wr_en) begin
            if (busy_old) m_err = 1;
            else if (wr_rtc_on != m_en) begin
               m_en = wr_rtc_on; m_busy = 1; t0 = cyc;
            end
         end
         if (busy_old) begin
            if (cyc == t0 + SYNC) begin
               if (m_en) m_sw = 1; else m_rst = 0;
            end else if (cyc == t0 + SYNC + 1) begin
               if (m_en) begin m_rst = 1; m_sts = 1; end
               else begin m_sw = 0; m_sts = 0; end
               m_busy = 0;
            end
         end
         if (bkp_exit) m_sram = 1;
         else if (bkp_enter) m_sram = m_keep;
         if (wr_en) m_keep = wr_sram_keep;
         sel_new = (m_mode == 1) ? 1 : (m_mode == 2) ? 2 : 0;
         m_lrst = (m_sel != 0) && (m_sel == sel_new);
         m_sel = sel_new;
         if (wr_en) m_mode = int'(wr_lcd_mode);
      end
   end

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         chk("R1 rtc_sw_on", rtc_sw_on, m_sw);
         chk("R2 rtc_dom_rst_n", rtc_dom_rst_n, m_rst);
         chk("R4 rtc_sts", rtc_sts, m_sts);
         chk("R5 seq_err", seq_err, m_err);
         chk("R7 sram_sw_on", sram_sw_on, m_sram);
         chk("R9 lcd_sel_ext", lcd_sel_ext, m_sel == 1);
         chk("R9 lcd_sel_pump", lcd_sel_pump, m_sel == 2);
         chk("R10 lcd_dom_rst_n", lcd_dom_rst_n, m_lrst);
      end
   end

   always @(posedge clk) begin
      if (!done && cyc > WD_LIMIT) begin
         n_chk++; n_fail++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   // drive at a falling edge; the strobe is sampled at the next rising edge
   task automatic do_write(input logic on, input logic keep, input logic [1:0] mode,
                           input logic clr = 1'b0);
      wr_en = 1'b1; wr_rtc_on = on; wr_sram_keep = keep; wr_lcd_mode = mode; err_clr = clr;
      @(negedge clk);
      wr_en = 1'b0; err_clr = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_bkp(input logic ent, input logic ext);
      bkp_enter = ent; bkp_exit = ext;
      @(negedge clk);
      bkp_enter = 1'b0; bkp_exit = 1'b0;
   endtask

   initial begin
      idle(3);
      chk("R6 reset rtc_sw_on", rtc_sw_on, 1'b0);
      chk("R6 reset rtc_dom_rst_n", rtc_dom_rst_n, 1'b0);
      chk("R6 reset sram_sw_on", sram_sw_on, 1'b1);
      chk("R6 reset lcd_dom_rst_n", lcd_dom_rst_n, 1'b0);
      rst_n = 1'b1;
      idle(2);
      // power-up with a colliding write inside the sequence
      do_write(1'b1, 1'b0, 2'd0);
      do_write(1'b0, 1'b0, 2'd0);
      idle(4);
      chk("R1 powered after sequence", rtc_dom_rst_n, 1'b1);
      chk("R5 collision flagged", seq_err, 1'b1);
      err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
      chk("R5 error cleared", seq_err, 1'b0);
      // same-value write
      do_write(1'b1, 1'b0, 2'd0);
      idle(5);
      chk("R3 same-value switch kept", rtc_sw_on, 1'b1);
      chk("R3 same-value reset kept", rtc_dom_rst_n, 1'b1);
      chk("R3 same-value no error", seq_err, 1'b0);
      // power-down, then a write at the last busy edge and the first free edge
      do_write(1'b0, 1'b0, 2'd0);
      idle(2);
      do_write(1'b1, 1'b0, 2'd0);
      do_write(1'b1, 1'b0, 2'd0);
      idle(5);
      chk("R5 write at first free edge accepted", rtc_sts, 1'b1);
      // set and clear in the same cycle: set wins
      err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
      do_write(1'b0, 1'b0, 2'd0);
      do_write(1'b0, 1'b0, 2'd0, 1'b1);
      chk("R5 set beats clear", seq_err, 1'b1);
      idle(5);
      do_write(1'b0, 1'b0, 2'd0, 1'b1);
      // LCD modes
      do_write(1'b0, 1'b0, 2'd1); idle(3);
      do_write(1'b0, 1'b0, 2'd2); idle(3);
      chk("R9 pump selected", lcd_sel_pump, 1'b1);
      do_write(1'b0, 1'b0, 2'd3); idle(3);
      chk("R9 mode 3 selects none", lcd_sel_ext | lcd_sel_pump, 1'b0);
      chk("R10 mode 3 holds reset", lcd_dom_rst_n, 1'b0);
      do_write(1'b0, 1'b0, 2'd1); idle(3);
      do_write(1'b0, 1'b0, 2'd0); idle(3);
      // SRAM retention
      do_write(1'b0, 1'b0, 2'd0); idle(2);
      chk("R7 keep write has no immediate effect", sram_sw_on, 1'b1);
      pulse_bkp(1'b1, 1'b0); idle(1);
      chk("R7 entry opens switch", sram_sw_on, 1'b0);
      pulse_bkp(1'b0, 1'b1); idle(1);
      chk("R8 exit closes switch", sram_sw_on, 1'b1);
      do_write(1'b0, 1'b1, 2'd0); idle(1);
      pulse_bkp(1'b1, 1'b0); idle(1);
      chk("R7 entry keeps switch", sram_sw_on, 1'b1);
      do_write(1'b0, 1'b0, 2'd0); idle(1);
      pulse_bkp(1'b1, 1'b1); idle(1);
      chk("R8 exit beats entry", sram_sw_on, 1'b1);
      idle(2);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule